// File: doc/BRIEF.md
# Packed-Pixel Line Plotter

This block draws a straight line into a packed frame buffer held in byte-wide memory. A single command carries the two endpoints, the byte address of the buffer, the buffer width in pixels and a depth code that selects 2, 4 or 8 bits per pixel. The engine walks from the first endpoint to the second using an integer error term. For every point it plots, it either overwrites the byte that holds the pixel or performs a read-modify-write on it. At 2 and 4 bits per pixel, plotting clears the pixel's bits to zero. At 8 bits per pixel, plotting sets the whole byte to all ones.

A client raises `start` for one cycle while the engine is idle. The engine then drives the memory port until the line is complete and pulses `done`. A line whose endpoints coincide is dropped. A command with an unsupported depth code is also dropped. In both cases `done` pulses with no memory traffic. The block does no clipping and has no colour selection.

Top module: `pk_line_engine`

## Requirements
- R1: Each access addresses byte `fb_base + (((y*fb_width + x) << depth_code) >> 3)` for the pixel (x, y) being plotted. The depth codes are 1 = 2 bpp, 2 = 4 bpp and 3 = 8 bpp.
- R2: At 2 bpp the engine reads the byte, then writes it back with bits [s+1:s] cleared, where s = (3 - x mod 4)*2. The lowest x in a byte sits in the most significant bits.
- R3: At 4 bpp the engine reads the byte, then writes it back with bits [s+3:s] cleared, where s = (1 - x mod 2)*4.
- R4: At 8 bpp each point is a single write of 0xFF, and the engine issues no read.
- R5: With the larger of |x1-x0| and |y1-y0| as the step count, exactly step+1 points are written, including both endpoints. When |dy| equals |dx|, y is the major axis.
- R6: The error term starts at step/2. At each point, after plotting, it drops by the minor length. If the result is negative, step is added back and the minor coordinate advances by one for the next point.
- R7: The sign of x1-x0 and of y1-y0 sets the direction of travel on each axis, so all eight octants are drawn correctly.
- R8: A command whose endpoints are equal causes no memory access, and `done` pulses in the cycle after `start`.
- R9: Depth code 0 causes no memory access, and `done` pulses in the cycle after `start`.
- R10: `busy` is high from the cycle after an accepted `start` until the final write is acknowledged. `done` is a single-cycle pulse with `busy` low. Memory strobes are active only while `busy` is high.
- R11: A `start` raised while `busy` is high is ignored, and the line in progress completes unchanged.
- R12: `mem_rd` and `mem_wr` are never high together. A strobe, its address and its write data stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted when idle |
| x0 | input | COORD_W | First endpoint x |
| y0 | input | COORD_W | First endpoint y |
| x1 | input | COORD_W | Second endpoint x |
| y1 | input | COORD_W | Second endpoint y |
| fb_base | input | ADDR_W | Byte address of the buffer |
| fb_width | input | COORD_W | Buffer width in pixels |
| depth_code | input | 2 | 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp, 0 = unsupported |
| busy | output | 1 | Line in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Read strobe, held until ack |
| mem_wr | output | 1 | Write strobe, held until ack |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with ack |
| mem_ack | input | 1 | Access complete |

## Verification
A dropped command (R8, R9) raises `done` at the first clock edge after `start`. An accepted line raises `busy` at that same edge. Both are sampled on the next falling edge. Each pixel's read and write is checked at the falling edge on which the bench memory raises `mem_ack`, so the check happens once per access no matter how long the variable acknowledge delay is. The end of a line is taken as the falling edge after the final write's ack. At that edge the bench expects `done` high, `busy` low and the full expected point count already consumed, and one edge later it expects `done` low again.

// File: rtl/pkl_pkg.sv
package pkl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } pkl_state_e;

    localparam logic [1:0] CODE_NONE = 2'd0;
    localparam logic [1:0] CODE_2BPP = 2'd1;
    localparam logic [1:0] CODE_4BPP = 2'd2;
    localparam logic [1:0] CODE_8BPP = 2'd3;
endpackage

// File: rtl/pkl_octant.sv
// Classifies a line: major axis, step count, minor length and travel directions.
module pkl_octant #(
    parameter int COORD_W = 10
) (
    input  logic [COORD_W-1:0] xa,
    input  logic [COORD_W-1:0] ya,
    input  logic [COORD_W-1:0] xb,
    input  logic [COORD_W-1:0] yb,
    output logic [COORD_W-1:0] step,
    output logic [COORD_W-1:0] minor_len,
    output logic               x_major,
    output logic               neg_x,
    output logic               neg_y
);
    localparam int DW = COORD_W + 1;

    logic signed [DW-1:0] dx_s, dy_s;
    logic [DW-1:0]        ax_w, ay_w;
    logic [COORD_W-1:0]   ax, ay;

    always_comb begin
        dx_s    = $signed({1'b0, xb}) - $signed({1'b0, xa});
        dy_s    = $signed({1'b0, yb}) - $signed({1'b0, ya});
        ax_w    = dx_s[DW-1] ? DW'(-dx_s) : DW'(dx_s);
        ay_w    = dy_s[DW-1] ? DW'(-dy_s) : DW'(dy_s);
        ax      = ax_w[COORD_W-1:0];
        ay      = ay_w[COORD_W-1:0];
        neg_x   = dx_s[DW-1];
        neg_y   = dy_s[DW-1];
        x_major = (ay < ax);
        step      = x_major ? ax : ay;
        minor_len = x_major ? ay : ax;
    end
endmodule

// File: rtl/pkl_addr.sv
// Byte address of a packed pixel.
module pkl_addr #(
    parameter int COORD_W = 10,
    parameter int ADDR_W  = 24
) (
    input  logic [COORD_W-1:0] px,
    input  logic [COORD_W-1:0] py,
    input  logic [COORD_W-1:0] width,
    input  logic [ADDR_W-1:0]  base,
    input  logic [1:0]         code,
    output logic [ADDR_W-1:0]  addr
);
    localparam int IDX_W = 2 * COORD_W + 1;
    localparam int BIT_W = IDX_W + 3;

    logic [IDX_W-1:0] idx;
    logic [BIT_W-1:0] bit_off;
    logic [BIT_W-1:0] byte_off;

    always_comb begin
        idx      = IDX_W'(py) * IDX_W'(width) + IDX_W'(px);
        bit_off  = BIT_W'(idx) << code;
        byte_off = bit_off >> 3;
        addr     = base + ADDR_W'(byte_off);
    end
endmodule

// File: rtl/pkl_merge.sv
// Clears the bits of one pixel inside a fetched byte, lowest x in the top bits.
module pkl_merge (
    input  logic [1:0] code,
    input  logic [1:0] x_lo,
    input  logic [7:0] rbyte,
    output logic [7:0] cleared
);
    import pkl_pkg::*;

    logic [2:0] sh;
    logic [7:0] mask;

    always_comb begin
        sh   = 3'd0;
        mask = 8'hFF;
        unique case (code)
            CODE_2BPP: begin
                sh   = {~x_lo, 1'b0};
                mask = 8'h03 << sh;
            end
            CODE_4BPP: begin
                sh   = {~x_lo[0], 2'b00};
                mask = 8'h0F << sh;
            end
            default: begin
                sh   = 3'd0;
                mask = 8'hFF;
            end
        endcase
        cleared = rbyte & ~mask;
    end
endmodule

// File: rtl/pk_line_engine.sv
module pk_line_engine #(
    parameter int COORD_W = 10,
    parameter int ADDR_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] x0,
    input  logic [COORD_W-1:0] y0,
    input  logic [COORD_W-1:0] x1,
    input  logic [COORD_W-1:0] y1,
    input  logic [ADDR_W-1:0]  fb_base,
    input  logic [COORD_W-1:0] fb_width,
    input  logic [1:0]         depth_code,
    output logic               busy,
    output logic               done,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    input  logic [7:0]         mem_rdata,
    input  logic               mem_ack
);
    import pkl_pkg::*;

    localparam int ERR_W = COORD_W + 2;

    typedef struct packed {
        pkl_state_e         state;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [ERR_W-1:0]   err;
        logic [COORD_W-1:0] cnt;
        logic [COORD_W-1:0] step;
        logic [COORD_W-1:0] len;
        logic               xmaj;
        logic               negx;
        logic               negy;
        logic [ADDR_W-1:0]  base;
        logic [COORD_W-1:0] width;
        logic [1:0]         code;
        logic [7:0]         hold;
        logic               busy;
        logic               done;
    } eng_t;

    eng_t q, d;

    // command classification
    logic [COORD_W-1:0] cmd_step, cmd_len;
    logic               cmd_xmaj, cmd_negx, cmd_negy;

    pkl_octant #(.COORD_W(COORD_W)) u_oct (
        .xa(x0), .ya(y0), .xb(x1), .yb(y1),
        .step(cmd_step), .minor_len(cmd_len),
        .x_major(cmd_xmaj), .neg_x(cmd_negx), .neg_y(cmd_negy)
    );

    pkl_addr #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_addr (
        .px(q.x), .py(q.y), .width(q.width), .base(q.base),
        .code(q.code), .addr(mem_addr)
    );

    logic [7:0] cleared_byte;

    pkl_merge u_merge (
        .code(q.code), .x_lo(q.x[1:0]), .rbyte(mem_rdata), .cleared(cleared_byte)
    );

    // stepping arithmetic
    logic signed [ERR_W-1:0] err_sub, err_fix;
    logic                    borrow;
    logic [COORD_W-1:0]      x_adv, y_adv;
    pkl_state_e              pixel_entry;

    always_comb begin
        err_sub     = $signed(q.err) - $signed({2'b00, q.len});
        borrow      = err_sub[ERR_W-1];
        err_fix     = borrow ? (err_sub + $signed({2'b00, q.step})) : err_sub;
        x_adv       = q.negx ? (q.x - 1'b1) : (q.x + 1'b1);
        y_adv       = q.negy ? (q.y - 1'b1) : (q.y + 1'b1);
        pixel_entry = (q.code == CODE_8BPP) ? ST_WRITE : ST_READ;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.x     = x0;
                    d.y     = y0;
                    d.step  = cmd_step;
                    d.len   = cmd_len;
                    d.xmaj  = cmd_xmaj;
                    d.negx  = cmd_negx;
                    d.negy  = cmd_negy;
                    d.base  = fb_base;
                    d.width = fb_width;
                    d.code  = depth_code;
                    d.cnt   = '0;
                    d.err   = ERR_W'(cmd_step >> 1);
                    if ((depth_code == CODE_NONE) || (cmd_step == '0)) begin
                        d.done = 1'b1;
                    end else begin
                        d.busy  = 1'b1;
                        d.state = (depth_code == CODE_8BPP) ? ST_WRITE : ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    d.hold  = cleared_byte;
                    d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    if (q.cnt == q.step) begin
                        d.state = ST_IDLE;
                        d.busy  = 1'b0;
                        d.done  = 1'b1;
                    end else begin
                        d.cnt   = q.cnt + 1'b1;
                        d.err   = ERR_W'(err_fix);
                        d.state = pixel_entry;
                        if (q.xmaj) begin
                            d.x = x_adv;
                            if (borrow) d.y = y_adv;
                        end else begin
                            d.y = y_adv;
                            if (borrow) d.x = x_adv;
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic [1:0] cur_code;
    assign cur_code  = q.code;
    assign busy      = q.busy;
    assign done      = q.done;
    assign mem_rd    = (q.state == ST_READ);
    assign mem_wr    = (q.state == ST_WRITE);
    assign mem_wdata = (q.code == CODE_8BPP) ? 8'hFF : q.hold;
endmodule

// File: rtl/pkl_checker.sv
module pkl_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic [1:0]        cur_code
);
    p_excl_strobes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) && !mem_ack |=> (mem_rd || mem_wr) && $stable(mem_addr));

    p_hold_wdata_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && !mem_ack |=> mem_wr && $stable(mem_wdata));

    p_no_read_8bpp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (cur_code != 2'd3));

    p_access_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(mem_wr && mem_ack) |=> busy);

    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(cur_code));
endmodule

bind pk_line_engine pkl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cur_code(cur_code)
);

// File: tb/sim_pk_line_engine.sv
module sim_pk_line_engine;
    localparam int CW   = 5;
    localparam int AW   = 12;
    localparam int BASE = 'h100;
    localparam int WID  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] x0 = '0, y0 = '0, x1 = '0, y1 = '0;
    logic [AW-1:0] fb_base = AW'(BASE);
    logic [CW-1:0] fb_width = CW'(WID);
    logic [1:0]    depth_code = 2'd1;
    logic          busy, done, mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = 8'h00;
    logic          mem_ack = 1'b0;

    always #4 clk = ~clk;

    pk_line_engine #(.COORD_W(CW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x0(x0), .y0(y0), .x1(x1), .y1(y1),
        .fb_base(fb_base), .fb_width(fb_width), .depth_code(depth_code),
        .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int tests = 0;
    int fails = 0;
    logic [7:0] mem [0:4095];
    int exp_x [0:63];
    int exp_y [0:63];
    int n_exp = 0;
    int widx = 0;
    int ridx = 0;
    int acc_cnt = 0;
    int dly = 0;
    int code_i = 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic int e_addr(input int px, input int py, input int code);
        return BASE + (((py * WID + px) << code) >> 3);
    endfunction

    function automatic logic [7:0] e_clear(input logic [7:0] b, input int px, input int code);
        if (code == 1) return b & ~(8'h03 << ((3 - (px % 4)) * 2));
        if (code == 2) return b & ~(8'h0F << ((1 - (px % 2)) * 4));
        return 8'hFF;
    endfunction

    // memory responder: acts on falling edges, ack lasts one cycle
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if ((mem_rd || mem_wr) && dly > 0) begin
            dly--;
        end else if (mem_rd || mem_wr) begin
            acc_cnt++;
            dly = acc_cnt % 3;
            mem_ack = 1'b1;
            if (mem_rd) begin
                chk(code_i != 3, "R4 read at 8bpp", 1, 0);
                if (ridx < n_exp)
                    chk(int'(mem_addr) == e_addr(exp_x[ridx], exp_y[ridx], code_i),
                        "R1 read addr", int'(mem_addr), e_addr(exp_x[ridx], exp_y[ridx], code_i));
                ridx++;
                mem_rdata = mem[mem_addr];
            end else begin
                if (widx < n_exp) begin
                    chk(int'(mem_addr) == e_addr(exp_x[widx], exp_y[widx], code_i),
                        "R1/R6/R7 write addr", int'(mem_addr), e_addr(exp_x[widx], exp_y[widx], code_i));
                    chk(mem_wdata == e_clear(mem[mem_addr], exp_x[widx], code_i),
                        (code_i == 1) ? "R2 data" : ((code_i == 2) ? "R3 data" : "R4 data"),
                        int'(mem_wdata), int'(e_clear(mem[mem_addr], exp_x[widx], code_i)));
                end else begin
                    chk(1'b0, "R5 extra write", widx, n_exp);
                end
                mem[mem_addr] = mem_wdata;
                widx++;
            end
        end
    end

    task automatic build_expect(input int ax0, input int ay0, input int ax1, input int ay1);
        int dx = ax1 - ax0;
        int dy = ay1 - ay0;
        int adx = (dx < 0) ? -dx : dx;
        int ady = (dy < 0) ? -dy : dy;
        int sx = (dx < 0) ? -1 : 1;
        int sy = (dy < 0) ? -1 : 1;
        bit xm = (ady < adx);
        int stp = xm ? adx : ady;
        int ln = xm ? ady : adx;
        int j = stp / 2;
        int k = 0;
        n_exp = 0;
        if (stp != 0) begin
            for (int i = 0; i <= stp; i++) begin
                exp_x[i] = xm ? ax0 + sx * i : ax0 + sx * k;
                exp_y[i] = xm ? ay0 + sy * k : ay0 + sy * i;
                j -= ln;
                if (j < 0) begin
                    j += stp;
                    k++;
                end
            end
            n_exp = stp + 1;
        end
    endtask

    task automatic run_line(input int ax0, input int ay0, input int ax1, input int ay1,
                            input int code, input bit poke);
        int acc0;
        int guard;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 91);
        code_i = code;
        if (code == 0) n_exp = 0;
        else build_expect(ax0, ay0, ax1, ay1);
        widx = 0;
        ridx = 0;
        acc0 = acc_cnt;
        x0 = CW'(ax0); y0 = CW'(ay0); x1 = CW'(ax1); y1 = CW'(ay1);
        depth_code = 2'(code);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n_exp == 0) begin
            chk(done == 1'b1 && busy == 1'b0, (code == 0) ? "R9 dropped done" : "R8 dropped done",
                {busy, done}, 1);
            @(negedge clk);
            chk(acc_cnt == acc0 && done == 1'b0,
                (code == 0) ? "R9 no access" : "R8 no access", acc_cnt - acc0, 0);
        end else begin
            chk(busy == 1'b1, "R10 busy after start", busy, 1);
            guard = 0;
            while (!done && guard < 2000) begin
                if (poke && guard == 3) begin
                    x0 = CW'(ax1); y0 = CW'(ay1); x1 = CW'(ax0); y1 = 0;
                    depth_code = 2'd3 - 2'(code);
                    start = 1'b1;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                guard++;
            end
            start = 1'b0;
            chk(done == 1'b1 && busy == 1'b0, "R10 done with busy low", {busy, done}, 1);
            chk(widx == n_exp, "R5 point count", widx, n_exp);
            @(negedge clk);
            chk(done == 1'b0, "R10 done pulse", done, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && mem_rd == 0 && mem_wr == 0, "R10 reset state",
            {busy, done, mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 R6 R7: every direction from the centre, at each depth (R2 R3 R4)
        for (int c = 1; c <= 3; c++)
            for (int ex = 0; ex < 16; ex++)
                for (int ey = 0; ey < 16; ey++)
                    run_line(7, 7, ex, ey, c, 1'b0);
        // long diagonals and steep lines across the buffer
        for (int c = 1; c <= 3; c++) begin
            run_line(0, 0, 15, 9, c, 1'b0);
            run_line(15, 15, 0, 3, c, 1'b0);
            run_line(3, 14, 12, 0, c, 1'b0);
            run_line(0, 15, 15, 0, c, 1'b0);
        end
        // R8 single-point line, R9 unsupported depth
        run_line(5, 5, 5, 5, 3, 1'b0);
        run_line(1, 2, 13, 9, 0, 1'b0);
        // R11 start pulsed while busy
        run_line(2, 1, 14, 6, 1, 1'b1);
        run_line(14, 2, 3, 12, 2, 1'b1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule